// File: doc/BRIEF.md
# Cascadable Presettable Divide-by-N Counter

A synchronous programmable frequency divider made of a parameterised number of 4-bit down-counting digits. Every digit owns a 4-bit slice of the preset word, a borrow input from the digits below it and a cascade-feedback input from the digits above it. The digit's zero flag is high only when that digit and every more significant digit are zero. The zero flag of the least significant digit is the zero flag of the whole chain. A registered copy of it acts as the preset enable, so the counter reloads the divisor without outside help.

After reset, or whenever the chain reaches zero, the next clock edge loads the preset value. The zero state uses up one count, so the reload value is N-1 when the counter is not inhibited. The counter then steps down once per clock. The zero output therefore gives a pulse one clock wide every N clocks. An inhibit input freezes the count. When the reload edge happens under inhibit, the counter loads N itself and waits.

Top module: `divn_chain`

## Requirements
- R1: An active-high asynchronous reset sets every count bit to 0 and drives zero high at once, without waiting for a clock.
- R2: When zero is low and inhibit is low, the count drops by exactly one on each rising edge. A digit steps only when all less significant digits are 0, and it wraps from 0 to 15 when it borrows.
- R3: When zero is low and inhibit is high, the count keeps its value across clock edges.
- R4: The stage_zero bit of digit i is high exactly when digit i and all more significant digits are 0. The zero output equals stage_zero bit 0, and it is high exactly when the whole count is 0.
- R5: On the edge that ends a zero cycle, the counter loads N-1 when inhibit is low, or N when inhibit is high, where N is the preset value for a nonzero preset.
- R6: With a constant preset N of 1 or more and inhibit low, zero goes high once every N clocks. For N = 1 it stays high on every cycle.
- R7: With preset 0, zero stays high and the count stays 0.
- R8: The preset is read only on the reload edge. Changing it in the middle of a count does not change the next count value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| inhibit | input | 1 | Freezes counting while high |
| preset | input | 4*STAGES | Divisor N, one 4-bit digit per stage, least significant digit in bits 3:0 |
| count | output | 4*STAGES | Current count value |
| stage_zero | output | STAGES | Zero flag of each digit, qualified by cascade feedback from above |
| zero | output | 1 | Registered chain-zero flag; also drives the reload |

## Verification
The bench builds the counter three times, with one, two and three digits, and drives all three side by side from one behavioural integer model each. The single-digit copy reaches the largest one-digit divisor and N = 1. The two-digit copy with N = 16 and N = 37 exercises borrow and wrap across a digit boundary. The three-digit copy with N = 300 and N = 4095 carries the cascade feedback through a middle digit and runs the longest period.

// File: rtl/divn_chain.sv
module divn_chain #(
  parameter int STAGES  = 3,
  parameter int DIGIT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inhibit,
  input  logic [STAGES*DIGIT_W-1:0]   preset,
  output logic [STAGES*DIGIT_W-1:0]   count,
  output logic [STAGES-1:0]           stage_zero,
  output logic                        zero
);
  localparam int W = STAGES * DIGIT_W;

  logic [W-1:0]      cnt_q, cnt_dec, cnt_d, reload;
  logic              zero_q;
  logic [STAGES-1:0] borrow;
  logic [STAGES:1]   cf;

  assign borrow[0]  = ~inhibit;
  assign cf[STAGES] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_digit
    logic [DIGIT_W-1:0] dig;
    logic               dig_nil;
    assign dig     = cnt_q[i*DIGIT_W +: DIGIT_W];
    assign dig_nil = (dig == '0);
    assign stage_zero[i] = dig_nil & cf[i+1];
    if (i > 0) begin : g_cf
      assign cf[i] = stage_zero[i];
    end
    if (i < STAGES-1) begin : g_brw
      assign borrow[i+1] = borrow[i] & dig_nil;
    end
    assign cnt_dec[i*DIGIT_W +: DIGIT_W] = borrow[i] ? dig - 1'b1 : dig;
  end

  assign reload = (preset == '0) ? '0 :
                  inhibit        ? preset : preset - W'(1);
  assign cnt_d  = zero_q ? reload : cnt_dec;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      zero_q <= (cnt_d == '0);
    end
  end

  assign count = cnt_q;
  assign zero  = zero_q;

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !zero_q) |=> (cnt_q == $past(cnt_q)));                    // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!inhibit && !zero_q) |=> (cnt_q == $past(cnt_q) - W'(1)));           // R2
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (zero_q && !inhibit && preset != '0) |=> (cnt_q == $past(preset) - W'(1))); // R5
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero_q == (cnt_q == '0));                                             // R4
  AST_CHAIN_AGREE: assert property (@(posedge clk) disable iff (rst)
    zero_q == stage_zero[0]);                                             // R4
  AST_NULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (zero_q && preset == '0) |=> zero_q);                                 // R7
endmodule

// File: tb/divn_chain_tb.sv
module divn_chain_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        inhibit = 1'b0;
  logic [11:0] n_val [3];
  int checks = 0, errors = 0, cyc = 0;
  bit per_en = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  for (genvar k = 0; k < 3; k++) begin : g_dut
    localparam int S = k + 1;
    localparam int W = 4 * S;
    logic [W-1:0] cnt;
    logic [S-1:0] sz;
    logic         z;
    int m = 0;
    int last_z = -1;
    int n;
    assign n = int'(n_val[k][W-1:0]);

    divn_chain #(.STAGES(S), .DIGIT_W(4)) dut_i (
      .clk(clk), .rst(rst), .inhibit(inhibit), .preset(n_val[k][W-1:0]),
      .count(cnt), .stage_zero(sz), .zero(z));

    always @(posedge clk or posedge rst) begin
      if (rst)           m <= 0;
      else if (m == 0)   m <= (n == 0) ? 0 : (inhibit ? n : n - 1);
      else if (!inhibit) m <= m - 1;
    end

    always @(negedge clk) begin
      chk(int'(cnt) == m, $sformatf("R2 count S=%0d", S), cnt, m);
      chk(z == (m == 0), $sformatf("R4 zero S=%0d", S), z, m == 0);
      for (int i = 0; i < S; i++)
        chk(sz[i] == ((m >> (4*i)) == 0), $sformatf("R4 stage_zero[%0d] S=%0d", i, S),
            sz[i], (m >> (4*i)) == 0);
      if (!per_en || rst || n == 0) last_z = -1;
      else if (z) begin
        if (last_z >= 0)
          chk(cyc - last_z == n, $sformatf("R6 period S=%0d", S), cyc - last_z, n);
        last_z = cyc;
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    n_val[0] = 12'd5; n_val[1] = 12'd37; n_val[2] = 12'd300;
    step(3);
    chk(g_dut[2].cnt == 0, "R1 reset count", g_dut[2].cnt, 0);
    chk(g_dut[2].z == 1'b1, "R1 reset zero", g_dut[2].z, 1);
    chk(g_dut[0].z == 1'b1, "R1 reset zero S=1", g_dut[0].z, 1);
    rst = 1'b0;
    per_en = 1'b1;
    step(700);

    while (!g_dut[1].z) step(1);
    step(1);
    chk(g_dut[1].cnt == 36, "R5 reload N-1", g_dut[1].cnt, 36);

    per_en = 1'b0;
    step(5);
    c = int'(g_dut[2].cnt);
    inhibit = 1'b1;
    step(10);
    if (c != 0) chk(int'(g_dut[2].cnt) == c, "R3 hold under inhibit", g_dut[2].cnt, c);
    inhibit = 1'b0;
    step(3);

    c = int'(g_dut[2].cnt);
    n_val[2] = 12'd77;
    step(1);
    if (c > 1) chk(int'(g_dut[2].cnt) == c - 1, "R8 preset ignored mid-count", g_dut[2].cnt, c - 1);
    step(400);
    per_en = 1'b1;
    step(300);

    step(7);
    rst = 1'b1;
    #1;
    chk(g_dut[2].cnt == 0, "R1 async reset count", g_dut[2].cnt, 0);
    chk(g_dut[2].z == 1'b1, "R1 async reset zero", g_dut[2].z, 1);
    per_en = 1'b0;
    n_val[0] = 12'd0; n_val[1] = 12'd0; n_val[2] = 12'd0;
    step(2);
    rst = 1'b0;
    step(20);
    chk(g_dut[1].z == 1'b1, "R7 zero held for N=0", g_dut[1].z, 1);
    chk(g_dut[2].cnt == 0, "R7 count held for N=0", g_dut[2].cnt, 0);

    rst = 1'b1;
    n_val[0] = 12'd15; n_val[1] = 12'd16; n_val[2] = 12'd4095;
    step(2);
    rst = 1'b0;
    per_en = 1'b1;
    step(8300);

    per_en = 1'b0;
    rst = 1'b1;
    n_val[0] = 12'd1; n_val[1] = 12'd2; n_val[2] = 12'd3;
    step(2);
    rst = 1'b0;
    per_en = 1'b1;
    step(40);
    chk(g_dut[0].z == 1'b1, "R6 N=1 zero always high", g_dut[0].z, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule